// File: doc/BRIEF.md
# Scan Test Application Sequencer

This block runs a complete scan test session against a circuit whose state flops are stitched into one or more mux-D scan chains. It owns a small register-file pattern store. Each stored vector carries the state to load into every chain, the primary-input values to apply, the expected primary-output values, the expected captured state, and a per-position compare mask. A session applies a chosen number of vectors in order. For each vector the block shifts the state in, runs a single capture clock in functional mode, and then shifts the captured state out while the next vector's state shifts in.

The chains may have different lengths but share one test-control line. Every shift phase is as long as the longest chain. A shorter chain receives zero fill first, so that its real bits arrive last. At the end of each vector's unload the block reports a pass or fail verdict. It also keeps a sticky fail flag and the index of the first failing vector until the next session starts.

Top module: `scan_test_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `res_valid` and `fail_sticky` are 0, `tc` is 1, and `scan_in` and `pi` are 0.
- R2: A `start` pulse while idle with a nonzero `vec_cnt` begins a session. A `start` pulse while busy, or a `start` pulse with `vec_cnt` equal to 0, is ignored. A count above the store depth `NVEC` is clamped to `NVEC`.
- R3: `tc` is 0 in shift cycles and 1 otherwise. Each vector gets exactly NSFF consecutive shift cycles followed by exactly one capture cycle.
- R4: With NSFF the longest chain length and n the applied vector count, `busy` is high for exactly (NSFF+1)·n + NSFF consecutive cycles. `done` pulses for one cycle, in the cycle right after the last busy cycle.
- R5: In shift cycle j (0-based) of vector v, chain c drives stored bit c·NSFF+j of vector v. This holds only where chain c is long enough; see R6. During the final unload phase every `scan_in` bit is 0.
- R6: A chain of length L < NSFF drives 0 on its `scan_in` during shift cycles j < NSFF−L, whatever the stored bits are.
- R7: `po` is compared with the expected-output field only in the capture cycle, and all bits are compared.
- R8: During shift cycle j of the phase after a capture, chain c's `scan_out` is compared with expected bit c·NSFF+j of the captured vector. The compare happens only if the mask bit at the same position is 1 and j < L for that chain.
- R9: For each vector one `res_valid` pulse appears, in the cycle after the last shift cycle of its unload phase. The pulse carries `res_idx` equal to the vector index and `res_fail`, set if any compare of R7 or R8 failed. Reports come in vector order.
- R10: `fail_sticky` and `first_fail` capture the first failing vector of a session. They hold through idle time and are cleared only when a new session is accepted.
- R11: The store is written through `pat_we`, `pat_addr` and `pat_wdata`. Word layout from bit 0 upward: scan-in bits (NCH·NSFF), PI (NPI), expected scan-out (NCH·NSFF), mask (NCH·NSFF), expected PO (NPO). Chain c position j sits at offset c·NSFF+j within each per-chain field.
- R12: `pi` carries vector v's PI field through its shift phase and its capture cycle, and is 0 during the final unload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Session start pulse |
| vec_cnt | input | CW | Number of vectors to apply |
| pat_we | input | 1 | Pattern store write enable |
| pat_addr | input | AW | Pattern store write address |
| pat_wdata | input | W | Pattern store write word |
| scan_out | input | NCH | Last flop of each chain |
| po | input | NPO | Primary outputs of the circuit under test |
| tc | output | 1 | Test control: 0 shift, 1 capture or functional |
| busy | output | 1 | Session in progress |
| scan_in | output | NCH | Serial data into each chain |
| pi | output | NPI | Primary inputs to the circuit under test |
| done | output | 1 | One-cycle end-of-session pulse |
| res_valid | output | 1 | Per-vector verdict strobe |
| res_fail | output | 1 | Verdict: 1 means mismatch |
| res_idx | output | AW | Index of the reported vector |
| fail_sticky | output | 1 | Some vector failed in this session |
| first_fail | output | AW | Index of the first failing vector |

## Verification
A wrong shift or vector counter changes the `tc` cadence and the busy length, and both are visible within the first vector period. An off-by-one bit position corrupts the loaded state. That error shows only as false fail verdicts, one full shift phase after the capture, at the next `res_valid`. Broken padding shows directly on a short chain's `scan_in` in the first shift cycles. A faulty compare window or mask shows as a wrong `res_fail` at the end of the affected vector's unload. The same fault then appears in `fail_sticky` and `first_fail`.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CAPT  = 2'd2
  } seq_st_e;

  // length of chain c from a packed list of LW-bit length fields
  function automatic int unsigned len_of(input logic [63:0] lens,
                                         input int unsigned lw,
                                         input int unsigned c);
    logic [63:0] msk;
    msk = (64'd1 << lw) - 64'd1;
    return 32'((lens >> (c * lw)) & msk);
  endfunction

  function automatic int unsigned max_len(input logic [63:0] lens,
                                          input int unsigned lw,
                                          input int unsigned n);
    int unsigned m;
    m = 0;
    for (int unsigned i = 0; i < n; i++) begin
      if (len_of(lens, lw, i) > m) m = len_of(lens, lw, i);
    end
    return m;
  endfunction

endpackage

// File: rtl/scan_pat_store.sv
module scan_pat_store #(
  parameter int unsigned W     = 35,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 2,
  parameter int unsigned RA_LO = 0,
  parameter int unsigned RA_W  = 13,
  parameter int unsigned RB_LO = 13,
  parameter int unsigned RB_W  = 22
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [W-1:0]    wdata,
  input  logic [AW-1:0]   raddr_a,
  output logic [RA_W-1:0] rdata_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [RB_W-1:0] rdata_b
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  logic ok_a, ok_b;
  assign ok_a = ({1'b0, raddr_a} < (AW+1)'(DEPTH));
  assign ok_b = ({1'b0, raddr_b} < (AW+1)'(DEPTH));

  assign rdata_a = ok_a ? mem[raddr_a][RA_LO +: RA_W] : '0;
  assign rdata_b = ok_b ? mem[raddr_b][RB_LO +: RB_W] : '0;

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int unsigned NSFF = 5,
  parameter int unsigned NVEC = 4,
  parameter int unsigned CW   = 3,
  parameter int unsigned JW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] vec_cnt,
  output seq_st_e       st,
  output logic [JW-1:0] j,
  output logic [CW-1:0] v,
  output logic          unload,
  output logic          go,
  output logic          last_shift,
  output logic          done
);

  localparam logic [JW-1:0] JLAST = JW'(NSFF - 1);
  localparam logic [CW-1:0] CMAX  = CW'(NVEC);

  logic [CW-1:0] cnt_q;

  assign go         = (st == ST_IDLE) && start && (vec_cnt != '0);
  assign unload     = (v == cnt_q);
  assign last_shift = (st == ST_SHIFT) && (j == JLAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      j     <= '0;
      v     <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go) begin
            st    <= ST_SHIFT;
            j     <= '0;
            v     <= '0;
            cnt_q <= (vec_cnt > CMAX) ? CMAX : vec_cnt;
          end
        end
        ST_SHIFT: begin
          if (j == JLAST) begin
            j <= '0;
            if (unload) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              st <= ST_CAPT;
            end
          end else begin
            j <= j + 1'b1;
          end
        end
        ST_CAPT: begin
          st <= ST_SHIFT;
          v  <= v + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scan_resp_cmp.sv
module scan_resp_cmp
  import scan_seq_pkg::*;
#(
  parameter int unsigned NCH  = 2,
  parameter int unsigned LW   = 4,
  parameter logic [NCH*LW-1:0] CH_LEN = 8'h35,
  parameter int unsigned NSFF = 5,
  parameter int unsigned NPO  = 2,
  parameter int unsigned JW   = 3,
  parameter int unsigned CW   = 3,
  parameter int unsigned AW   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic                capt,
  input  logic                shift_cmp,
  input  logic                last_shift,
  input  logic [JW-1:0]       j,
  input  logic [CW-1:0]       v,
  input  logic [NCH*NSFF-1:0] exp_so,
  input  logic [NCH*NSFF-1:0] mask,
  input  logic [NPO-1:0]      exp_po,
  input  logic [NCH-1:0]      scan_out,
  input  logic [NPO-1:0]      po,
  output logic                res_valid,
  output logic                res_fail,
  output logic [AW-1:0]       res_idx,
  output logic                fail_sticky,
  output logic [AW-1:0]       first_fail
);

  logic [NCH-1:0] mm;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned L = len_of(64'(CH_LEN), LW, c);
    logic [NSFF-1:0] e_c, m_c;
    assign e_c   = exp_so[c*NSFF +: NSFF];
    assign m_c   = mask[c*NSFF +: NSFF];
    assign mm[c] = ({1'b0, j} < (JW+1)'(L)) && m_c[j] && (scan_out[c] != e_c[j]);
  end

  logic po_err_q, so_err_q, fail_now;
  logic [AW-1:0] prev_idx;

  assign fail_now = po_err_q | so_err_q | (|mm);
  assign prev_idx = AW'(v - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      po_err_q    <= 1'b0;
      so_err_q    <= 1'b0;
      res_valid   <= 1'b0;
      res_fail    <= 1'b0;
      res_idx     <= '0;
      fail_sticky <= 1'b0;
      first_fail  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (go) begin
        po_err_q    <= 1'b0;
        so_err_q    <= 1'b0;
        fail_sticky <= 1'b0;
        first_fail  <= '0;
      end
      if (capt) po_err_q <= (po != exp_po);
      if (shift_cmp) begin
        if (last_shift) begin
          res_valid <= 1'b1;
          res_fail  <= fail_now;
          res_idx   <= prev_idx;
          so_err_q  <= 1'b0;
          if (fail_now && !fail_sticky) begin
            fail_sticky <= 1'b1;
            first_fail  <= prev_idx;
          end
        end else begin
          so_err_q <= so_err_q | (|mm);
        end
      end
    end
  end

endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
#(
  parameter int unsigned NCH  = 2,
  parameter int unsigned LW   = 4,
  parameter logic [NCH*LW-1:0] CH_LEN = 8'h35,
  parameter int unsigned NPI  = 3,
  parameter int unsigned NPO  = 2,
  parameter int unsigned NVEC = 4,
  localparam int unsigned NSFF = max_len(64'(CH_LEN), LW, NCH),
  localparam int unsigned JW   = (NSFF > 1) ? $clog2(NSFF) : 1,
  localparam int unsigned AW   = (NVEC > 1) ? $clog2(NVEC) : 1,
  localparam int unsigned CW   = $clog2(NVEC + 1),
  localparam int unsigned SB   = NCH * NSFF,
  localparam int unsigned O_PI = SB,
  localparam int unsigned O_EX = O_PI + NPI,
  localparam int unsigned W    = O_EX + 2 * SB + NPO
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [CW-1:0]  vec_cnt,
  input  logic           pat_we,
  input  logic [AW-1:0]  pat_addr,
  input  logic [W-1:0]   pat_wdata,
  input  logic [NCH-1:0] scan_out,
  input  logic [NPO-1:0] po,
  output logic           tc,
  output logic           busy,
  output logic [NCH-1:0] scan_in,
  output logic [NPI-1:0] pi,
  output logic           done,
  output logic           res_valid,
  output logic           res_fail,
  output logic [AW-1:0]  res_idx,
  output logic           fail_sticky,
  output logic [AW-1:0]  first_fail
);

  seq_st_e       seq_st;
  logic [JW-1:0] seq_j;
  logic [CW-1:0] seq_v;
  logic          seq_unload, seq_go, seq_last;

  scan_seq_ctrl #(.NSFF(NSFF), .NVEC(NVEC), .CW(CW), .JW(JW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .vec_cnt(vec_cnt),
    .st(seq_st), .j(seq_j), .v(seq_v), .unload(seq_unload),
    .go(seq_go), .last_shift(seq_last), .done(done)
  );

  logic [SB+NPI-1:0]     ld_word;
  logic [2*SB+NPO-1:0]   rsp_word;

  scan_pat_store #(
    .W(W), .DEPTH(NVEC), .AW(AW),
    .RA_LO(0), .RA_W(SB + NPI), .RB_LO(O_EX), .RB_W(2 * SB + NPO)
  ) u_store (
    .clk(clk), .we(pat_we), .waddr(pat_addr), .wdata(pat_wdata),
    .raddr_a(AW'(seq_v)), .rdata_a(ld_word),
    .raddr_b(AW'(seq_v - 1'b1)), .rdata_b(rsp_word)
  );

  logic shifting, loading;
  assign shifting = (seq_st == ST_SHIFT);
  assign loading  = shifting && !seq_unload;

  assign busy = (seq_st != ST_IDLE);
  assign tc   = !shifting;
  assign pi   = (busy && !seq_unload) ? ld_word[SB +: NPI] : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_sin
    localparam int unsigned L = len_of(64'(CH_LEN), LW, c);
    logic [NSFF-1:0] s_c;
    assign s_c        = ld_word[c*NSFF +: NSFF];
    assign scan_in[c] = loading && ({1'b0, seq_j} >= (JW+1)'(NSFF - L)) && s_c[seq_j];
  end

  scan_resp_cmp #(
    .NCH(NCH), .LW(LW), .CH_LEN(CH_LEN), .NSFF(NSFF), .NPO(NPO),
    .JW(JW), .CW(CW), .AW(AW)
  ) u_cmp (
    .clk(clk), .rst(rst), .go(seq_go),
    .capt(seq_st == ST_CAPT),
    .shift_cmp(shifting && (seq_v != '0)),
    .last_shift(seq_last),
    .j(seq_j), .v(seq_v),
    .exp_so(rsp_word[0 +: SB]),
    .mask(rsp_word[SB +: SB]),
    .exp_po(ld_word_po_sel(rsp_word)),
    .scan_out(scan_out), .po(po),
    .res_valid(res_valid), .res_fail(res_fail), .res_idx(res_idx),
    .fail_sticky(fail_sticky), .first_fail(first_fail)
  );

  // expected-PO of the vector in capture lives in the load-side address,
  // so it is read through port B only once that vector is in its unload;
  // during capture the vector is still on port A's address (v), so fetch it
  // from a third, narrow read below instead.
  function automatic logic [NPO-1:0] ld_word_po_sel(input logic [2*SB+NPO-1:0] unused_w);
    return cap_po;
  endfunction

  logic [NPO-1:0] cap_po;
  scan_pat_store #(
    .W(W), .DEPTH(NVEC), .AW(AW),
    .RA_LO(O_EX + 2 * SB), .RA_W(NPO), .RB_LO(0), .RB_W(1)
  ) u_po_store (
    .clk(clk), .we(pat_we), .waddr(pat_addr), .wdata(pat_wdata),
    .raddr_a(AW'(seq_v)), .rdata_a(cap_po),
    .raddr_b('0), .rdata_b()
  );

endmodule

// File: rtl/scan_test_seq_chk.sv
module scan_test_seq_chk #(
  parameter int unsigned NCH  = 2,
  parameter int unsigned LW   = 4,
  parameter logic [NCH*LW-1:0] CH_LEN = 8'h35,
  parameter int unsigned NSFF = 5,
  parameter int unsigned JW   = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           tc,
  input logic           done,
  input logic           fail_sticky,
  input logic           res_valid,
  input logic [NCH-1:0] scan_in,
  input logic [JW-1:0]  j
);

  p_idle_normal_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tc);

  p_single_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && tc) |=> (busy && !tc));

  p_done_end_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_report_after_shift_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($past(busy) && !$past(tc)));

  p_sticky_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (fail_sticky && !start) |=> fail_sticky);

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (scan_in == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_pad
    localparam int unsigned L = scan_seq_pkg::len_of(64'(CH_LEN), LW, c);
    p_pad_zero_r6: assert property (@(posedge clk) disable iff (rst)
      (busy && !tc && ({1'b0, j} < (JW+1)'(NSFF - L))) |-> !scan_in[c]);
  end

endmodule

bind scan_test_seq scan_test_seq_chk #(
  .NCH(NCH), .LW(LW), .CH_LEN(CH_LEN), .NSFF(NSFF), .JW(JW)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .tc(tc), .done(done),
  .fail_sticky(fail_sticky), .res_valid(res_valid), .scan_in(scan_in),
  .j(seq_j)
);

// File: tb/test_scan_test_seq.sv
module test_scan_test_seq;

  localparam int W = 35;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, start, pat_we;
  logic [2:0] vec_cnt;
  logic [1:0] pat_addr;
  logic [W-1:0] pat_wdata;
  logic [1:0] scan_out, po, scan_in, res_idx, first_fail;
  logic [2:0] pi;
  logic tc, busy, done, res_valid, res_fail, fail_sticky;

  scan_test_seq i_scan_test_seq (
    .clk(clk), .rst(rst), .start(start), .vec_cnt(vec_cnt),
    .pat_we(pat_we), .pat_addr(pat_addr), .pat_wdata(pat_wdata),
    .scan_out(scan_out), .po(po), .tc(tc), .busy(busy), .scan_in(scan_in),
    .pi(pi), .done(done), .res_valid(res_valid), .res_fail(res_fail),
    .res_idx(res_idx), .fail_sticky(fail_sticky), .first_fail(first_fail)
  );

  // second build: three chains of lengths 2, 6, 1 (longest 6)
  logic       start_b;
  logic [2:0] vec_cnt_b;
  logic tc_b, busy_b, done_b, rv_b, rf_b, fs_b;
  logic [2:0] si_b, pi_b;
  logic [1:0] ri_b, ff_b;
  scan_test_seq #(.NCH(3), .CH_LEN(12'h162)) i_scan_test_seq_b (
    .clk(clk), .rst(rst), .start(start_b), .vec_cnt(vec_cnt_b),
    .pat_we(1'b0), .pat_addr(2'd0), .pat_wdata('0),
    .scan_out(3'b000), .po(2'b00), .tc(tc_b), .busy(busy_b), .scan_in(si_b),
    .pi(pi_b), .done(done_b), .res_valid(rv_b), .res_fail(rf_b),
    .res_idx(ri_b), .fail_sticky(fs_b), .first_fail(ff_b)
  );

  // circuit under test: chain0 5 flops, chain1 3 flops
  logic [4:0] c0 = '0;
  logic [2:0] c1 = '0;

  function automatic logic [4:0] nx0(input logic [4:0] s0, input logic [2:0] s1,
                                     input logic [2:0] p);
    return {s0[3:0], s1[2]} ^ {2'b00, p};
  endfunction
  function automatic logic [1:0] po_f(input logic [4:0] s0, input logic [2:0] s1,
                                      input logic [2:0] p);
    return {^s0, s1[0] ^ p[2]};
  endfunction

  assign scan_out = {c1[2], c0[4]};
  assign po       = po_f(c0, c1, pi);

  always_ff @(posedge clk) begin
    if (!tc) begin
      c0 <= {c0[3:0], scan_in[0]};
      c1 <= {c1[1:0], scan_in[1]};
    end else begin
      c0 <= nx0(c0, c1, pi);
      c1 <= c1 + pi;
    end
  end

  // stimulus table: {state chain0, state chain1, PI}
  localparam logic [10:0] TAB [4] = '{
    {5'h13, 3'h5, 3'h2}, {5'h0A, 3'h2, 3'h7},
    {5'h1F, 3'h0, 3'h1}, {5'h04, 3'h7, 3'h4}
  };

  logic [W-1:0] words [4];

  // R11 layout: sin[9:0] pi[12:10] exp_so[22:13] mask[32:23] exp_po[34:33]
  function automatic logic [W-1:0] mk(input logic [10:0] t);
    logic [W-1:0] w;
    logic [4:0] s0, n0;
    logic [2:0] s1, p, n1;
    s0 = t[10:6]; s1 = t[5:3]; p = t[2:0];
    n0 = nx0(s0, s1, p); n1 = s1 + p;
    w = '1;
    for (int j = 0; j < 5; j++) begin
      w[j]      = s0[4-j];
      w[13 + j] = n0[4-j];
      if (j >= 2) w[5 + j]  = s1[4-j];
      if (j < 3)  w[18 + j] = n1[2-j];
    end
    w[12:10] = p;
    w[34:33] = po_f(s0, s1, p);
    return w;
  endfunction

  int nrun = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor
  int bk, bk_b, rs_n, done_n, ncur;
  bit bad_tc, bad_si, bad_pad, bad_pi, bad_ord;
  logic [3:0] rs_fail;

  always @(negedge clk) begin
    if (busy) begin
      int vv, jj;
      logic e0, e1;
      vv = bk / 6; jj = bk % 6;
      if (tc != (jj == 5)) bad_tc = 1'b1;
      e0 = 1'b0; e1 = 1'b0;
      if (vv < ncur && jj < 5) begin
        e0 = words[vv][jj];
        if (jj >= 2) e1 = words[vv][5 + jj];
      end
      if (scan_in[0] != e0) bad_si = 1'b1;
      if (scan_in[1] != e1) bad_pad = 1'b1;
      if (pi != ((vv < ncur) ? words[vv][12:10] : 3'd0)) bad_pi = 1'b1;
      bk++;
    end
    if (busy_b) bk_b++;
    if (res_valid) begin
      if (int'(res_idx) != rs_n) bad_ord = 1'b1;
      rs_fail[res_idx] = res_fail;
      rs_n++;
    end
    if (done) done_n++;
  end

  task automatic clr_mon(input int n);
    bk = 0; bk_b = 0; rs_n = 0; done_n = 0; ncur = n;
    bad_tc = 0; bad_si = 0; bad_pad = 0; bad_pi = 0; bad_ord = 0; rs_fail = '0;
  endtask

  task automatic wr(input int a);
    @(negedge clk);
    pat_we = 1'b1; pat_addr = 2'(a); pat_wdata = words[a];
    @(negedge clk);
    pat_we = 1'b0;
  endtask

  task automatic run(input logic [2:0] n, input int nexp, input bit repulse);
    clr_mon(nexp);
    @(negedge clk); start = 1'b1; vec_cnt = n;
    @(negedge clk); start = 1'b0;
    if (repulse) begin
      repeat (7) @(negedge clk);
      start = 1'b1; vec_cnt = 3'd1;
      @(negedge clk); start = 1'b0;
    end
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done_n > 0) break;
    end
    repeat (2) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nrun++; nfail++;
      $display("FAIL R4 watchdog: actual %0d cycles expected below %0d", cyc, 20000);
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; vec_cnt = '0; pat_we = 1'b0; pat_addr = '0;
    pat_wdata = '0; start_b = 1'b0; vec_cnt_b = '0;
    clr_mon(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(tc == 1, "R1 tc", tc, 1);
    chk(done == 0 && res_valid == 0, "R1 done/res_valid", done | res_valid, 0);
    chk(fail_sticky == 0, "R1 fail_sticky", fail_sticky, 0);
    chk(scan_in == 0 && pi == 0, "R1 scan_in/pi", {scan_in, pi}, 0);

    for (int v = 0; v < 4; v++) begin
      words[v] = mk(TAB[v]);
      wr(v);
    end

    // all vectors match
    run(3'd4, 4, 1'b0);
    chk(bk == 29, "R4 busy length n=4", bk, 29);
    chk(done_n == 1, "R4 done pulses", done_n, 1);
    chk(bad_tc == 0, "R3 tc cadence", bad_tc, 0);
    chk(bad_si == 0, "R5 scan_in order", bad_si, 0);
    chk(bad_pad == 0, "R6 padding on short chain", bad_pad, 0);
    chk(bad_pi == 0, "R12 pi drive", bad_pi, 0);
    chk(rs_n == 4 && !bad_ord, "R9 report count/order", rs_n, 4);
    chk(rs_fail == 4'b0000, "R5 all vectors pass", rs_fail, 0);
    chk(fail_sticky == 0, "R10 no sticky on pass", fail_sticky, 0);

    // wrong expected PO on vector 2
    words[2][33] ^= 1'b1; wr(2);
    run(3'd4, 4, 1'b0);
    chk(rs_fail == 4'b0100, "R7 PO mismatch vector 2 (R11 rewrite)", rs_fail, 4);
    chk(fail_sticky && first_fail == 2, "R10 first fail 2", first_fail, 2);
    words[2][33] ^= 1'b1; wr(2);
    repeat (5) @(negedge clk);
    chk(fail_sticky == 1, "R10 sticky held while idle", fail_sticky, 1);

    // wrong expected scan-out: vector 1 chain0 j=1, vector 3 chain0 j=3
    words[1][14] ^= 1'b1; wr(1);
    words[3][16] ^= 1'b1; wr(3);
    run(3'd4, 4, 1'b0);
    chk(rs_fail == 4'b1010, "R8 scan-out mismatches", rs_fail, 10);
    chk(first_fail == 1, "R10 first fail 1", first_fail, 1);

    // mask the bad bit of vector 1, restore vector 3, corrupt out-of-window bit
    words[3][16] ^= 1'b1; wr(3);
    words[1][24] = 1'b0;   wr(1);
    words[0][22] ^= 1'b1;  wr(0);
    run(3'd4, 4, 1'b0);
    chk(rs_fail == 4'b0000, "R8 mask and length window", rs_fail, 0);
    chk(fail_sticky == 0, "R10 cleared at start", fail_sticky, 0);

    // start while busy ignored; count clamp
    run(3'd4, 4, 1'b1);
    chk(bk == 29 && rs_n == 4, "R2 start while busy ignored", bk, 29);
    run(3'd7, 4, 1'b0);
    chk(bk == 29, "R2 count clamped to depth", bk, 29);
    clr_mon(0);
    @(negedge clk); start = 1'b1; vec_cnt = 3'd0;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    chk(bk == 0, "R2 zero count ignored", bk, 0);

    run(3'd1, 1, 1'b0);
    chk(bk == 11, "R4 busy length n=1", bk, 11);
    chk(rs_n == 1 && rs_fail[0] == 0, "R9 single report", rs_n, 1);

    // other build: longest chain 6
    clr_mon(0);
    @(negedge clk); start_b = 1'b1; vec_cnt_b = 3'd3;
    @(negedge clk); start_b = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done_b) break;
    end
    chk(bk_b == 27, "R4 busy length 3 chains n=3", bk_b, 27);
    clr_mon(0);
    @(negedge clk); start_b = 1'b1; vec_cnt_b = 3'd1;
    @(negedge clk); start_b = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done_b) break;
    end
    chk(bk_b == 13, "R4 busy length 3 chains n=1", bk_b, 13);

    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

endmodule